// File: doc/BRIEF.md
# Fixed-Priority Interrupt Latch with Nesting Mask

This block collects interrupt requests for a signal-processing core, holds them in a latch register, and hands the core one vectored interrupt at a time. Hardware lines set latch bits directly. The lowest-priority levels are software interrupts, which have no pin: software raises them by writing ones into the latch. Each bit has a fixed priority, with bit 0 (reset) the highest, and a fixed vector slot. The vector address is the slot index times a stride, added to one of two table bases. An input picks the base, so the table can sit in the internal or the external memory region.

Recognition is a small state machine. `S_IDLE` picks the best eligible pending bit (transition *accept*) and moves to `S_RECOG`. From `S_RECOG` it goes to `S_BRANCH` (transition *direct*), or to `S_MPWAIT` for sources flagged as multiprocessor-sourced (transition *stall*). `S_MPWAIT` counts extra cycles and then moves to `S_BRANCH` (transition *release*). `S_BRANCH` presents the vector, strobes the PC push and returns to `S_IDLE` (transition *enter*), setting the bit in the nesting mask. A return strobe in `S_IDLE` moves to `S_RETURN` (transition *leave*) when something is in service. `S_RETURN` strobes the PC pop, and the status pop where that applies. It then returns to `S_IDLE` (transition *restore*) and clears the serviced bit in both the latch and the nesting mask. The PC stack and the status stack are outside the block; it only drives their strobes.

Top module: `irq_latch_nest`

## Requirements
- R1: After reset the latch, the nesting mask, `vec_valid`, `pc_push` and `pc_pop` are all zero.
- R2: A hardware request high before a clock edge sets latch bit i (bit i = `irq_req[i]`) at that edge. A `sw_set` write sets every latch bit that is one in `sw_bits`. A bit that is latched but blocked stays set.
- R3: When several bits are eligible together, the lowest index is serviced first.
- R4: Bits 1..N-1 are recognized only when `glob_en` is 1 and their `irq_mask` bit is 1. Bit 0 ignores both.
- R5: With the core running and no stall source, `vec_valid` and `pc_push` go high for exactly one cycle, after the third rising edge counted from the edge that latches the request.
- R6: `vec_addr` equals the base plus index times `VEC_STRIDE`. The base is `EXT_BASE` when `ext_region` is 1 and `INT_BASE` otherwise (bench: 0x20000 / 0x40000, stride 4).
- R7: On entry the serviced bit is set in `nest_q`. While any bit j is set there, latched bits of index j or higher are not recognized, but lower indices still are.
- R8: `rti` in idle with a non-empty nesting mask gives a one-cycle `pc_pop`. One edge later, the lowest set nesting bit is cleared in both `nest_q` and `latch_q`.
- R9: `sts_push` at entry and `sts_pop` at return are high only for bits set in `STS_SRC_MASK` (bench: bits 1 and 2).
- R10: A bit set in `MP_SRC_MASK` (bench: bit 4) waits `MP_EXTRA` extra cycles, so the vector appears after the sixth edge.
- R11: No interrupt is accepted while `core_run` is 0. Pending bits are accepted once it returns to 1.
- R12: `rti` with an empty nesting mask has no effect: no `pc_pop`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | N_IRQ-N_SW | Hardware request lines, bit i maps to latch bit i |
| sw_set | input | 1 | Write strobe that sets latch bits |
| sw_bits | input | N_IRQ | Bits to set on `sw_set` |
| glob_en | input | 1 | Global recognition enable |
| irq_mask | input | N_IRQ | Per-bit enable |
| core_run | input | 1 | Core executing or idle, so interrupts may be taken |
| ext_region | input | 1 | Selects the external vector table base |
| rti | input | 1 | Return-from-interrupt strobe |
| vec_valid | output | 1 | Vector presented (branch cycle) |
| vec_addr | output | ADDR_W | Vector address |
| pc_push | output | 1 | Push PC onto the PC stack |
| sts_push | output | 1 | Push status for this source |
| pc_pop | output | 1 | Pop PC stack on return |
| sts_pop | output | 1 | Pop status stack on return |
| latch_q | output | N_IRQ | Latch register |
| nest_q | output | N_IRQ | Nesting mask (levels in service) |

## Verification
The bench builds the block with eight levels, the top three of which are software levels. Bit 4 is flagged as multiprocessor-sourced with three extra cycles, bits 1 and 2 push status, and the two table bases are 0x20000 and 0x40000. These values put the six-cycle stall path, both table bases and the status-pop gating within reach in a few hundred cycles. They also allow a nesting depth of two with a blocked lower software level beneath it.

// File: rtl/irqn_pkg.sv
package irqn_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_RECOG,
        S_MPWAIT,
        S_BRANCH,
        S_RETURN
    } irqn_state_e;
endpackage

// File: rtl/irqn_latch.sv
module irqn_latch #(
    parameter int N_IRQ = 8,
    parameter int HW_N  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [HW_N-1:0]  hw_req,
    input  logic             sw_set,
    input  logic [N_IRQ-1:0] sw_bits,
    input  logic [N_IRQ-1:0] clr_bits,
    output logic [N_IRQ-1:0] latch_q
);
    logic [N_IRQ-1:0] set_bits;

    always_comb begin
        set_bits = {{(N_IRQ-HW_N){1'b0}}, hw_req};
        if (sw_set) set_bits = set_bits | sw_bits;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) latch_q <= '0;
        else        latch_q <= (latch_q & ~clr_bits) | set_bits;
    end
endmodule

// File: rtl/irqn_select.sv
module irqn_select #(
    parameter int N_IRQ = 8,
    parameter int IDX_W = 3
) (
    input  logic [N_IRQ-1:0] cand,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N_IRQ-1; i >= 0; i--) begin
            if (cand[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irqn_seq.sv
module irqn_seq
    import irqn_pkg::*;
#(
    parameter int               N_IRQ        = 8,
    parameter int               IDX_W        = 3,
    parameter int               ADDR_W       = 20,
    parameter int               VEC_STRIDE   = 4,
    parameter logic [ADDR_W-1:0] INT_BASE    = 20'h20000,
    parameter logic [ADDR_W-1:0] EXT_BASE    = 20'h40000,
    parameter logic [N_IRQ-1:0] MP_SRC_MASK  = 8'b0001_0000,
    parameter logic [N_IRQ-1:0] STS_SRC_MASK = 8'b0000_0110,
    parameter int               MP_EXTRA     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pend_found,
    input  logic [IDX_W-1:0]  pend_idx,
    input  logic              nest_found,
    input  logic [IDX_W-1:0]  nest_idx,
    input  logic              rti,
    input  logic              ext_region,
    output logic              vec_valid,
    output logic [ADDR_W-1:0] vec_addr,
    output logic              pc_push,
    output logic              sts_push,
    output logic              pc_pop,
    output logic              sts_pop,
    output logic [N_IRQ-1:0]  clr_bits,
    output logic [N_IRQ-1:0]  nest_q
);
    localparam int CNT_W = $clog2(MP_EXTRA + 1);

    irqn_state_e       state_q, state_d;
    logic [IDX_W-1:0]  cur_idx_q, ret_idx_q;
    logic [ADDR_W-1:0] base_q;
    logic [CNT_W-1:0]  cnt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (rti && nest_found) state_d = S_RETURN;
                else if (pend_found)   state_d = S_RECOG;
            end
            S_RECOG:  state_d = MP_SRC_MASK[cur_idx_q] ? S_MPWAIT : S_BRANCH;
            S_MPWAIT: if (cnt_q == CNT_W'(MP_EXTRA - 1)) state_d = S_BRANCH;
            S_BRANCH: state_d = S_IDLE;
            S_RETURN: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_idx_q <= '0;
            ret_idx_q <= '0;
            base_q    <= '0;
            cnt_q     <= '0;
            nest_q    <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (rti && nest_found) begin
                        ret_idx_q <= nest_idx;
                    end else if (pend_found) begin
                        cur_idx_q <= pend_idx;
                        base_q    <= ext_region ? EXT_BASE : INT_BASE;
                    end
                    cnt_q <= '0;
                end
                S_MPWAIT: cnt_q <= cnt_q + 1'b1;
                S_BRANCH: nest_q[cur_idx_q] <= 1'b1;
                S_RETURN: nest_q[ret_idx_q] <= 1'b0;
                default: ;
            endcase
        end
    end

    always_comb begin
        vec_valid = 1'b0;
        pc_push   = 1'b0;
        sts_push  = 1'b0;
        pc_pop    = 1'b0;
        sts_pop   = 1'b0;
        clr_bits  = '0;
        vec_addr  = base_q + ADDR_W'(cur_idx_q) * ADDR_W'(VEC_STRIDE);
        unique case (state_q)
            S_BRANCH: begin
                vec_valid = 1'b1;
                pc_push   = 1'b1;
                sts_push  = STS_SRC_MASK[cur_idx_q];
            end
            S_RETURN: begin
                pc_pop              = 1'b1;
                sts_pop             = STS_SRC_MASK[ret_idx_q];
                clr_bits[ret_idx_q] = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/irq_latch_nest.sv
module irq_latch_nest #(
    parameter int               N_IRQ        = 8,
    parameter int               N_SW         = 3,
    parameter int               ADDR_W       = 20,
    parameter int               VEC_STRIDE   = 4,
    parameter logic [ADDR_W-1:0] INT_BASE    = 20'h20000,
    parameter logic [ADDR_W-1:0] EXT_BASE    = 20'h40000,
    parameter logic [N_IRQ-1:0] MP_SRC_MASK  = 8'b0001_0000,
    parameter logic [N_IRQ-1:0] STS_SRC_MASK = 8'b0000_0110,
    parameter int               MP_EXTRA     = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [N_IRQ-N_SW-1:0]   irq_req,
    input  logic                    sw_set,
    input  logic [N_IRQ-1:0]        sw_bits,
    input  logic                    glob_en,
    input  logic [N_IRQ-1:0]        irq_mask,
    input  logic                    core_run,
    input  logic                    ext_region,
    input  logic                    rti,
    output logic                    vec_valid,
    output logic [ADDR_W-1:0]       vec_addr,
    output logic                    pc_push,
    output logic                    sts_push,
    output logic                    pc_pop,
    output logic                    sts_pop,
    output logic [N_IRQ-1:0]        latch_q,
    output logic [N_IRQ-1:0]        nest_q
);
    localparam int HW_N  = N_IRQ - N_SW;
    localparam int IDX_W = $clog2(N_IRQ);

    logic [N_IRQ-1:0] clr_bits, allow, gate, eligible;
    logic             pend_found, nest_found;
    logic [IDX_W-1:0] pend_idx, nest_idx;

    irqn_latch #(.N_IRQ(N_IRQ), .HW_N(HW_N)) u_latch (
        .clk(clk), .rst_n(rst_n), .hw_req(irq_req), .sw_set(sw_set),
        .sw_bits(sw_bits), .clr_bits(clr_bits), .latch_q(latch_q)
    );

    for (genvar g = 0; g < N_IRQ; g++) begin : g_allow
        assign allow[g] = ~|nest_q[g:0];
        if (g == 0) begin : g_rst
            assign gate[g] = 1'b1;
        end else begin : g_norm
            assign gate[g] = glob_en & irq_mask[g];
        end
    end

    assign eligible = latch_q & gate & allow & {N_IRQ{core_run}};

    irqn_select #(.N_IRQ(N_IRQ), .IDX_W(IDX_W)) u_sel_pend (
        .cand(eligible), .found(pend_found), .idx(pend_idx)
    );

    irqn_select #(.N_IRQ(N_IRQ), .IDX_W(IDX_W)) u_sel_nest (
        .cand(nest_q), .found(nest_found), .idx(nest_idx)
    );

    irqn_seq #(
        .N_IRQ(N_IRQ), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .VEC_STRIDE(VEC_STRIDE),
        .INT_BASE(INT_BASE), .EXT_BASE(EXT_BASE), .MP_SRC_MASK(MP_SRC_MASK),
        .STS_SRC_MASK(STS_SRC_MASK), .MP_EXTRA(MP_EXTRA)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .pend_found(pend_found), .pend_idx(pend_idx),
        .nest_found(nest_found), .nest_idx(nest_idx), .rti(rti),
        .ext_region(ext_region), .vec_valid(vec_valid), .vec_addr(vec_addr),
        .pc_push(pc_push), .sts_push(sts_push), .pc_pop(pc_pop),
        .sts_pop(sts_pop), .clr_bits(clr_bits), .nest_q(nest_q)
    );
endmodule

// File: rtl/irqn_checker.sv
module irqn_checker #(
    parameter int N_IRQ = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             vec_valid,
    input logic             pc_push,
    input logic             sts_push,
    input logic             pc_pop,
    input logic             sts_pop,
    input logic [N_IRQ-1:0] latch_q,
    input logic [N_IRQ-1:0] nest_q
);
    assert_vec_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> !vec_valid);

    assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !((vec_valid || pc_push) && pc_pop));

    assert_nest_grows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> ($countones(nest_q) == $countones($past(nest_q)) + 1));

    assert_nest_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!vec_valid && !pc_pop) |=> $stable(nest_q));

    assert_ret_shrinks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pc_pop |=> ($countones(nest_q) + 1 == $countones($past(nest_q))));

    assert_nest_in_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (nest_q & ~latch_q) == '0);

    assert_sts_pop_paired_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sts_pop |-> pc_pop);

    assert_sts_push_paired_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sts_push |-> vec_valid);
endmodule

bind irq_latch_nest irqn_checker #(.N_IRQ(N_IRQ)) u_irqn_checker (
    .clk(clk), .rst_n(rst_n), .vec_valid(vec_valid), .pc_push(pc_push),
    .sts_push(sts_push), .pc_pop(pc_pop), .sts_pop(sts_pop),
    .latch_q(latch_q), .nest_q(nest_q)
);

// File: tb/tb_irq_latch_nest.sv
module tb_irq_latch_nest;
    localparam int N = 8;
    localparam int HW = 5;
    localparam logic [19:0] IB = 20'h20000;
    localparam logic [19:0] EB = 20'h40000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [HW-1:0] irq_req = '0;
    logic sw_set = 1'b0, glob_en = 1'b1, core_run = 1'b1, ext_region = 1'b0, rti = 1'b0;
    logic [N-1:0] sw_bits = '0, irq_mask = '1;
    logic vec_valid, pc_push, sts_push, pc_pop, sts_pop;
    logic [19:0] vec_addr;
    logic [N-1:0] latch_q, nest_q;
    int n_tests = 0, n_fail = 0;

    always #2 clk = ~clk;

    irq_latch_nest dut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .sw_set(sw_set), .sw_bits(sw_bits),
        .glob_en(glob_en), .irq_mask(irq_mask), .core_run(core_run),
        .ext_region(ext_region), .rti(rti), .vec_valid(vec_valid), .vec_addr(vec_addr),
        .pc_push(pc_push), .sts_push(sts_push), .pc_pop(pc_pop), .sts_pop(sts_pop),
        .latch_q(latch_q), .nest_q(nest_q)
    );

    // fields: [20:16] hw, [15:8] sw, [7] ext, [6:4] idx, [3:0] latency
    localparam logic [20:0] CASES [5] = '{
        {5'b00100, 8'h00, 1'b0, 3'd2, 4'd3},
        {5'b01000, 8'h00, 1'b1, 3'd3, 4'd3},
        {5'b00000, 8'h20, 1'b0, 3'd5, 4'd3},
        {5'b00000, 8'h80, 1'b1, 3'd7, 4'd3},
        {5'b10000, 8'h00, 1'b1, 3'd4, 4'd6}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic expect_vec(input int edges, input int idx, input string req);
        for (int k = 1; k <= edges; k++) begin
            @(posedge clk); @(negedge clk);
            irq_req = '0; sw_set = 1'b0; sw_bits = '0;
            chk(vec_valid == (k == edges), req, {31'b0, vec_valid}, {31'b0, k == edges});
        end
        chk(pc_push == 1'b1, {req, " push"}, {31'b0, pc_push}, 32'd1);
        chk(vec_addr == (ext_region ? EB : IB) + 20'(idx * 4), "R6 addr",
            {12'b0, vec_addr}, {12'b0, (ext_region ? EB : IB) + 20'(idx * 4)});
        chk(sts_push == (idx == 1 || idx == 2), "R9 sts_push",
            {31'b0, sts_push}, {31'b0, idx == 1 || idx == 2});
        @(posedge clk); @(negedge clk);
        chk(nest_q[idx] == 1'b1, "R7 nest set", {24'b0, nest_q}, 32'(1 << idx));
    endtask

    task automatic expect_none(input int edges, input string req);
        for (int k = 1; k <= edges; k++) begin
            @(posedge clk); @(negedge clk);
            irq_req = '0; sw_set = 1'b0; sw_bits = '0;
            chk(vec_valid == 1'b0, req, {31'b0, vec_valid}, 32'd0);
        end
    endtask

    task automatic do_rti(input int idx);
        rti = 1'b1;
        @(posedge clk); @(negedge clk);
        rti = 1'b0;
        chk(pc_pop == 1'b1, "R8 pc_pop", {31'b0, pc_pop}, 32'd1);
        chk(sts_pop == (idx == 1 || idx == 2), "R9 sts_pop",
            {31'b0, sts_pop}, {31'b0, idx == 1 || idx == 2});
        @(posedge clk); @(negedge clk);
        chk(nest_q[idx] == 1'b0 && latch_q[idx] == 1'b0, "R8 cleared",
            {nest_q, latch_q}, 32'd0);
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk(latch_q == '0 && nest_q == '0, "R1 regs", {latch_q, nest_q}, 32'd0);
        chk(!vec_valid && !pc_push && !pc_pop, "R1 strobes",
            {vec_valid, pc_push, pc_pop}, 32'd0);

        // table walk: R2 R5 R6 R9 R10
        foreach (CASES[c]) begin
            irq_req    = CASES[c][20:16];
            sw_bits    = CASES[c][15:8];
            sw_set     = |CASES[c][15:8];
            ext_region = CASES[c][7];
            expect_vec(int'(CASES[c][3:0]), int'(CASES[c][6:4]),
                       CASES[c][3:0] == 4'd6 ? "R10 latency" : "R5 latency");
            do_rti(int'(CASES[c][6:4]));
        end
        ext_region = 1'b0;

        // R3 priority: hw3 and sw5 together
        irq_req = 5'b01000; sw_set = 1'b1; sw_bits = 8'h20;
        expect_vec(3, 3, "R3 first");
        do_rti(3);
        expect_vec(2, 5, "R3 second");
        do_rti(5);

        // R4 mask blocks, R2 bit remains latched
        irq_mask = 8'b1111_0111; irq_req = 5'b01000;
        expect_none(6, "R4 masked");
        chk(latch_q[3] == 1'b1, "R2 held", {24'b0, latch_q}, 32'h8);
        irq_mask = '1;
        expect_vec(2, 3, "R4 unmasked");
        do_rti(3);

        // R4 global enable off
        glob_en = 1'b0; irq_req = 5'b00100;
        expect_none(5, "R4 glob_en");
        glob_en = 1'b1;
        expect_vec(2, 2, "R4 glob_en on");
        do_rti(2);

        // R4 reset bit ignores gating
        glob_en = 1'b0; irq_mask = '0; irq_req = 5'b00001;
        expect_vec(3, 0, "R4 reset bit");
        do_rti(0);
        glob_en = 1'b1; irq_mask = '1;

        // R7 nesting
        sw_set = 1'b1; sw_bits = 8'h40;
        expect_vec(3, 6, "R7 enter 6");
        sw_set = 1'b1; sw_bits = 8'h80;
        expect_none(6, "R7 lower hidden");
        irq_req = 5'b00010;
        expect_vec(3, 1, "R7 higher preempts");
        chk(nest_q == 8'h42, "R7 nest", {24'b0, nest_q}, 32'h42);
        do_rti(1);
        do_rti(6);
        expect_vec(2, 7, "R7 released");
        do_rti(7);

        // R11 core not running
        core_run = 1'b0; irq_req = 5'b01000;
        expect_none(6, "R11 blocked");
        core_run = 1'b1;
        expect_vec(2, 3, "R11 resumed");
        do_rti(3);

        // R12 rti with empty nest
        rti = 1'b1;
        @(posedge clk); @(negedge clk);
        rti = 1'b0;
        chk(pc_pop == 1'b0, "R12 no pop", {31'b0, pc_pop}, 32'd0);
        @(posedge clk); @(negedge clk);
        chk(pc_pop == 1'b0 && nest_q == '0, "R12 idle", {pc_pop, nest_q}, 32'd0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule